// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block decides, cycle by cycle, whether a small processor core may advance. It does so through a core clock-enable strobe, and it also makes one shared tick for the serial port, the output clock and the timer. A running core can request idle at full rate, idle at a slowed rate, or power-down. In slowed idle, the core and the peripheral tick are enabled once every n reference cycles. The ratio n is picked by a 2-bit code from 16, 32, 64 and 128.

A pending unmasked interrupt ends plain idle in the next cycle. In slowed idle, the interrupt takes effect at the next enabled slot. Power-down removes every enable. An interrupt starts a recovery window of fixed length, and the core enable returns only when that window ends. A context-keep choice is captured on power-down entry and reported at exit. Cycle-steal memory requests are still granted in both idle modes. Every return to running gives a single-cycle resume pulse, so the core continues with the instruction after its idle request.

Top module: `lpc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is running: `core_en`=1, `periph_tick`=1, `resume_pulse`=0, `ctx_kept`=0.
- R2: Slow idle is entered when `idle_req`=1 and `idle_slow`=1 while running. `idle_div` selects n: 00→16, 01→32, 10→64, 11→128. The first `core_en` pulse falls n cycles after the entry cycle, and each later pulse comes exactly n cycles after the previous one.
- R3: Plain idle is entered when `idle_req`=1 and `idle_slow`=0. In plain idle, `core_en`=0 and `periph_tick`=1 on every cycle. When `irq_pending` is high in plain idle, `core_en` is 1 in the next cycle.
- R4: In slow idle, `periph_tick` is high in exactly the cycles where `core_en` pulses.
- R5: In slow idle, an interrupt takes effect at the next enabled slot. Running resumes within n cycles of the interrupt being raised; raised k cycles after a pulse (1≤k≤n), the delay is n+1−k.
- R6: `dma_grant` follows `dma_req` while running and in both idle modes, and a request does not end idle. `dma_grant` is 0 in power-down and in recovery.
- R7: `pd_force` while running enters power-down, and it has priority over a simultaneous `idle_req`. In power-down, `core_en` and `periph_tick` are both 0. An interrupt is followed by exactly 200 cycles with `core_en`=0, after which `core_en` returns to 1.
- R8: Reset during power-down returns the block to running at the next clock edge, with `ctx_kept`=0.
- R9: `pd_keep_ctx` is sampled only in the power-down entry cycle. `ctx_kept` takes that value in the first running cycle after recovery and otherwise holds.
- R10: `resume_pulse` is 1 for exactly one cycle, the first running cycle after any exit from idle or power-down.
- R11: `idle_req` and `pd_force` are ignored unless the block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Request to enter an idle mode |
| idle_slow | input | 1 | 1 selects slowed idle, 0 plain idle |
| idle_div | input | 2 | Divide code for slowed idle |
| pd_force | input | 1 | Software power-down force |
| pd_keep_ctx | input | 1 | 1 keeps context across power-down, 0 clears it |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| dma_req | input | 1 | Cycle-steal memory request |
| core_en | output | 1 | Core clock-enable strobe |
| periph_tick | output | 1 | Shared serial, output-clock and timer tick |
| dma_grant | output | 1 | Cycle-steal grant |
| resume_pulse | output | 1 | One-cycle pulse when running resumes |
| ctx_kept | output | 1 | Context status reported at power-down exit |

## Verification
The assertions check these rules on every cycle:
- power-down and recovery stay silent;
- the slow-idle tick always coincides with the core pulse;
- no slow-idle gap reaches the largest ratio;
- plain idle wakes in the next cycle;
- grants are given in idle;
- the resume pulse never lasts more than one cycle;
- recovery always ends after its full count;
- the context status moves only on recovery exit.

Only the bench scenarios can show:
- the exact spacing for each of the four divide codes;
- the wake delay measured from a chosen offset after a pulse;
- the priority of power-down over idle;
- that requests outside running are ignored;
- the kept and cleared context values seen at exit.

// File: rtl/lpc_pkg.sv
// Shared definitions for the low-power clock controller.
// Assumes: one reference clock; every state is encoded in three bits.
package lpc_pkg;

    // Controller operating states
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_SLOW    = 3'd2,
        ST_PDOWN   = 3'd3,
        ST_RECOVER = 3'd4
    } lpc_state_e;

endpackage

// File: rtl/lpc_slot_div.sv
// Slot divider for slowed idle. On load it stores the divide code and
// starts counting down from n-1, where n = 2**(BASE_LOG2+code). While
// running it raises slot for one cycle at each terminal count and reloads.
// Assumes: load and run are never high together.
module lpc_slot_div #(
    parameter int BASE_LOG2 = 4,
    parameter int CODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              run,
    output logic              slot
);
    localparam int DIV_W = BASE_LOG2 + (1 << CODE_W) - 1;

    logic [DIV_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code_q;

    // Terminal count n-1 for a divide code
    function automatic logic [DIV_W-1:0] last_of(input logic [CODE_W-1:0] c);
        logic [DIV_W:0] span;
        span = (DIV_W+1)'(1) << (BASE_LOG2 + int'(c));
        return DIV_W'(span - (DIV_W+1)'(1));
    endfunction

    assign slot = run && (cnt_q == '0);

    // Count down, reloading at each slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (load) begin
            cnt_q  <= last_of(code);
            code_q <= code;
        end else if (run) begin
            cnt_q  <= (cnt_q == '0) ? last_of(code_q) : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/lpc_recover_cnt.sv
// Fixed-length recovery timer. When start is high, it loads REC_CYCLES-1.
// While run is high, it counts down, and done is high in the final
// (REC_CYCLES-th) running cycle.
// Assumes: REC_CYCLES >= 1; start is never high while run is high.
module lpc_recover_cnt #(
    parameter int REC_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int          RW   = $clog2(REC_CYCLES + 1);
    localparam logic [RW-1:0] LAST = RW'(REC_CYCLES - 1);

    logic [RW-1:0] cnt_q;

    assign done = run && (cnt_q == '0);

    // Load on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (start)                 cnt_q <= LAST;
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/lpc_ctrl.sv
// Idle and power-down clock controller (top).
// Sequences the states running, plain idle, slowed idle, power-down and
// recovery. From the state it drives the core enable, the shared
// peripheral tick and the cycle-steal grant. It also gives the resume
// pulse and the context status.
// Assumes: irq_pending already has masking applied; all inputs are
// synchronous to clk.
module lpc_ctrl #(
    parameter int BASE_LOG2  = 4,
    parameter int REC_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic       idle_slow,
    input  logic [1:0] idle_div,
    input  logic       pd_force,
    input  logic       pd_keep_ctx,
    input  logic       irq_pending,
    input  logic       dma_req,
    output logic       core_en,
    output logic       periph_tick,
    output logic       dma_grant,
    output logic       resume_pulse,
    output logic       ctx_kept
);
    import lpc_pkg::*;

    localparam int CODE_W = 2;

    lpc_state_e state_q, state_d;
    logic       accept_pd, accept_idle, div_load, slot;
    logic       rec_start, rec_done, exit_now;
    logic       ctx_sel_q, resume_q, ctx_kept_q;

    assign accept_pd   = (state_q == ST_RUN) && pd_force;
    assign accept_idle = (state_q == ST_RUN) && idle_req && !pd_force;
    assign div_load    = accept_idle && idle_slow;
    assign rec_start   = (state_q == ST_PDOWN) && irq_pending;

    lpc_slot_div #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .code  (idle_div),
        .run   (state_q == ST_SLOW),
        .slot  (slot)
    );

    lpc_recover_cnt #(.REC_CYCLES(REC_CYCLES)) i_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rec_start),
        .run   (state_q == ST_RECOVER),
        .done  (rec_done)
    );

    // Any exit that returns to running at the next edge
    assign exit_now = ((state_q == ST_IDLE) && irq_pending)
                   || ((state_q == ST_SLOW) && slot && irq_pending)
                   || rec_done;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept_pd)        state_d = ST_PDOWN;
                else if (accept_idle) state_d = idle_slow ? ST_SLOW : ST_IDLE;
            end
            ST_IDLE:    if (irq_pending)          state_d = ST_RUN;
            ST_SLOW:    if (slot && irq_pending)  state_d = ST_RUN;
            ST_PDOWN:   if (irq_pending)          state_d = ST_RECOVER;
            ST_RECOVER: if (rec_done)             state_d = ST_RUN;
            default:                              state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Resume pulse, context capture and context report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q   <= 1'b0;
            ctx_sel_q  <= 1'b0;
            ctx_kept_q <= 1'b0;
        end else begin
            resume_q <= exit_now;
            if (accept_pd) ctx_sel_q  <= pd_keep_ctx;
            if (rec_done)  ctx_kept_q <= ctx_sel_q;
        end
    end

    // Output strobes from the current state
    always_comb begin
        core_en     = (state_q == ST_RUN) || ((state_q == ST_SLOW) && slot);
        periph_tick = (state_q == ST_RUN) || (state_q == ST_IDLE)
                   || ((state_q == ST_SLOW) && slot);
        dma_grant   = dma_req && ((state_q == ST_RUN) || (state_q == ST_IDLE)
                                  || (state_q == ST_SLOW));
    end

    assign resume_pulse = resume_q;
    assign ctx_kept     = ctx_kept_q;
endmodule

// File: rtl/lpc_ctrl_chk.sv
// Property checker for lpc_ctrl, attached by bind. It observes the
// controller state together with the ports. Two counters bound the
// windows that depend on parameters: the gap between slow-idle pulses
// and the length of recovery.
// Assumes: MAXN is the largest slow-idle ratio.
module lpc_ctrl_chk
    import lpc_pkg::*;
#(
    parameter int MAXN       = 128,
    parameter int REC_CYCLES = 200
) (
    input logic       clk,
    input logic       rst_n,
    input lpc_state_e state,
    input logic       irq_pending,
    input logic       dma_req,
    input logic       core_en,
    input logic       periph_tick,
    input logic       dma_grant,
    input logic       resume_pulse,
    input logic       ctx_kept
);
    localparam int GW = $clog2(MAXN + 1) + 1;
    localparam int RW = $clog2(REC_CYCLES + 1) + 1;

    logic [GW-1:0] gap_q;
    logic [RW-1:0] rec_q;

    // Cycles since the last core pulse in slowed idle
    always_ff @(posedge clk) begin
        if (!rst_n || core_en || state != ST_SLOW) gap_q <= '0;
        else                                       gap_q <= gap_q + 1'b1;
    end

    // Cycles spent in recovery so far
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RECOVER) rec_q <= '0;
        else                               rec_q <= rec_q + 1'b1;
    end

    assert_slow_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOW) |-> (gap_q < GW'(MAXN)));

    assert_plain_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq_pending) |=> (state == ST_RUN && core_en));

    assert_slow_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOW) |-> (core_en == periph_tick));

    assert_dma_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_SLOW) && dma_req) |-> dma_grant);

    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN || state == ST_RECOVER) |-> (!core_en && !periph_tick && !dma_grant));

    assert_rec_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |-> (rec_q < RW'(REC_CYCLES)));

    assert_rec_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && rec_q == RW'(REC_CYCLES - 1)) |=> (state == ST_RUN));

    assert_ctx_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ctx_kept != $past(ctx_kept)) |-> ($past(state) == ST_RECOVER));

    assert_resume_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);
endmodule

bind lpc_ctrl lpc_ctrl_chk #(
    .MAXN       (1 << (BASE_LOG2 + 3)),
    .REC_CYCLES (REC_CYCLES)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .irq_pending  (irq_pending),
    .dma_req      (dma_req),
    .core_en      (core_en),
    .periph_tick  (periph_tick),
    .dma_grant    (dma_grant),
    .resume_pulse (resume_pulse),
    .ctx_kept     (ctx_kept)
);

// File: tb/test_lpc_ctrl.sv
// Self-checking bench for lpc_ctrl. It sweeps all four divide codes, the
// plain idle path, power-down with both context choices, and reset out of
// power-down. Inputs are driven and outputs sampled at falling edges.
module test_lpc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0, idle_slow = 1'b0;
    logic [1:0] idle_div = 2'b00;
    logic       pd_force = 1'b0, pd_keep_ctx = 1'b0;
    logic       irq_pending = 1'b0, dma_req = 1'b0;
    logic       core_en, periph_tick, dma_grant, resume_pulse, ctx_kept;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    lpc_ctrl i_lpc_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_slow(idle_slow),
        .idle_div(idle_div), .pd_force(pd_force), .pd_keep_ctx(pd_keep_ctx),
        .irq_pending(irq_pending), .dma_req(dma_req), .core_en(core_en),
        .periph_tick(periph_tick), .dma_grant(dma_grant),
        .resume_pulse(resume_pulse), .ctx_kept(ctx_kept)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(core_en == 1 && periph_tick == 1, "R1 enables", {core_en, periph_tick}, 3);
        chk(resume_pulse == 0 && ctx_kept == 0, "R1 status", {resume_pulse, ctx_kept}, 0);

        // Slowed idle across every divide code
        for (int code = 0; code < 4; code++) begin
            int n, k, d, lat, mism;
            n = 16 << code;
            mism = 0;
            idle_req = 1; idle_slow = 1; idle_div = code[1:0];
            tick();
            idle_req = 0; idle_div = 2'b00;
            k = 1;
            while (!core_en && k < 1000) begin
                if (periph_tick != core_en) mism++;
                tick(); k++;
            end
            chk(k == n, "R2 first slot", k, n);
            k = 0;
            do begin
                tick(); k++;
                if (periph_tick != core_en) mism++;
            end while (!core_en && k < 1000);
            chk(k == n, "R2 slot interval", k, n);
            d = (code % 2 == 1) ? n / 2 : 1;
            repeat (d) begin
                tick();
                if (periph_tick != core_en) mism++;
            end
            irq_pending = 1;
            lat = 0;
            do begin
                tick(); lat++;
                if (!resume_pulse && periph_tick != core_en) mism++;
            end while (!resume_pulse && lat < 1000);
            chk(mism == 0, "R4 tick matches core", mism, 0);
            chk(lat == n + 1 - d, "R5 wake latency", lat, n + 1 - d);
            chk(lat <= n, "R5 latency bound", lat, n);
            chk(core_en == 1, "R5 running after wake", core_en, 1);
            irq_pending = 0;
            tick();
            chk(resume_pulse == 0, "R10 pulse single", resume_pulse, 0);
        end

        // Plain idle with cycle steals and an ignored power-down request
        idle_req = 1; idle_slow = 0;
        tick();
        idle_req = 0;
        chk(core_en == 0 && periph_tick == 1, "R3 plain idle enables", {core_en, periph_tick}, 1);
        dma_req = 1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(dma_grant == 1 && core_en == 0, "R6 grant in idle", {dma_grant, core_en}, 2);
        end
        dma_req = 0;
        pd_force = 1;
        tick();
        pd_force = 0;
        tick();
        chk(periph_tick == 1 && core_en == 0, "R11 pd ignored in idle", {periph_tick, core_en}, 2);
        irq_pending = 1;
        tick();
        chk(core_en == 1 && resume_pulse == 1, "R3 one-cycle wake", {core_en, resume_pulse}, 3);
        irq_pending = 0;
        tick();

        // Power-down with each context choice; the later flip must be ignored
        for (int kk = 0; kk < 2; kk++) begin
            int lows;
            pd_force = 1; pd_keep_ctx = kk[0]; idle_req = 1; idle_slow = 0;
            tick();
            pd_force = 0; idle_req = 0; pd_keep_ctx = ~kk[0];
            chk(core_en == 0 && periph_tick == 0, "R7 power-down silent", {core_en, periph_tick}, 0);
            dma_req = 1;
            tick();
            chk(dma_grant == 0, "R6 no grant in power-down", dma_grant, 0);
            dma_req = 0;
            idle_req = 1; idle_slow = 0;
            tick();
            idle_req = 0;
            tick();
            chk(periph_tick == 0, "R11 idle ignored in power-down", periph_tick, 0);
            irq_pending = 1;
            lows = 0;
            do begin
                tick();
                if (!core_en) lows++;
            end while (!core_en && lows < 1000);
            irq_pending = 0;
            chk(lows == 200, "R7 recovery length", lows, 200);
            chk(resume_pulse == 1, "R10 pulse after power-down", resume_pulse, 1);
            chk(ctx_kept == kk[0], "R9 context report", ctx_kept, kk);
            tick();
        end

        // Reset ends power-down and clears the context status
        pd_force = 1; pd_keep_ctx = 1;
        tick();
        pd_force = 0;
        chk(core_en == 0, "R8 in power-down", core_en, 0);
        rst_n = 0;
        tick();
        rst_n = 1;
        chk(core_en == 1 && ctx_kept == 0, "R8 reset exit", {core_en, ctx_kept}, 2);
        tick();
        chk(core_en == 1 && periph_tick == 1, "R8 running after reset", {core_en, periph_tick}, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule